// File: doc/BRIEF.md
# Sequential Side-Attached Integer Divider

This block is a multicycle unsigned-magnitude divider that sits beside a single-stage execute unit. The requester has already reduced signed operands to magnitudes. It pulses `start` together with the dividend and divisor magnitudes and a small set of operation flags, and it then stalls until the divider reports completion. The flags select quotient or remainder, mark the operation as signed, request two's-complement negation of the answer, and enable overflow reporting.

The divider uses restoring shift-subtract and retires one quotient bit per clock. After `WIDTH` iteration cycles a single finalising cycle selects the quotient or the remainder, applies negation when requested, forces the answer to zero on a zero divisor, and evaluates overflow. It then raises `valid` for exactly one cycle with `result` and `overflow` beside it. A `start` that arrives while an operation is in flight is ignored.

Top module: `sdiv_unit`

## Requirements
- R1: With `op_mod`=0 and a nonzero divisor, the magnitude of `result` is floor(dividend / divisor).
- R2: With `op_mod`=1 and a nonzero divisor, the magnitude of `result` is dividend mod divisor.
- R3: With `neg_res`=1, `result` is the two's complement (modulo 2^WIDTH) of the magnitude from R1/R2. With `neg_res`=0 it is the magnitude itself.
- R4: `valid` is high for exactly one cycle. It rises after the WIDTH+1-th rising edge that follows the edge on which `start` was accepted.
- R5: A `start` seen while an operation is in progress is ignored. The running operation completes with its own operands and timing.
- R6: A zero divisor gives `result`=0, and it gives `overflow`=1 when `ovf_en`=1.
- R7: With `op_signed`=1, `ovf_en`=1 and a nonzero divisor, `overflow` is 1 when `neg_res`=1 and the magnitude exceeds 2^(WIDTH-1). It is also 1 when `neg_res`=0 and the magnitude is at least 2^(WIDTH-1). Otherwise it is 0.
- R8: A zero magnitude with `neg_res`=1 and a nonzero divisor never reports overflow.
- R9: `overflow` is 0 whenever `ovf_en`=0, and it is never high without `valid`.
- R10: After reset, `valid`, `overflow` and `result` are 0 and the unit accepts a new `start`.
- R11: With `op_signed`=0 and a nonzero divisor, `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| dividend | input | WIDTH | Dividend magnitude |
| divisor | input | WIDTH | Divisor magnitude |
| op_mod | input | 1 | 1 selects remainder, 0 selects quotient |
| op_signed | input | 1 | Operation is signed (enables range overflow check) |
| neg_res | input | 1 | Negate the magnitude result |
| ovf_en | input | 1 | Enable overflow reporting |
| result | output | WIDTH | Final result, held until the next completion |
| valid | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Overflow indication, meaningful with valid |

## Verification
The bench builds the unit with WIDTH=16 rather than the default 64. Each operation therefore takes 17 cycles, and random operands land often near the signed boundary 2^15. At that width the exact edges of R7 (magnitudes 0x8000 and 0x8001 with either negate setting) are reached by directed cases. Random draws also hit them at a useful rate. The 16-bit size also allows several hundred mixed quotient, remainder, zero-divisor and negated-zero operations within a short run, and each is checked for latency as well as value.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic fin,
  output logic busy
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  sdiv_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign accept  = (state_q == ST_IDLE) && start;
  assign step_en = (state_q == ST_RUN);
  assign fin     = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             step_en,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o,
  output logic             dz_o
);
  localparam int SW = 2 * WIDTH;

  // One restoring step: returns {next_rem, next_quo}
  function automatic logic [SW-1:0] restore_step(
    input logic [WIDTH-1:0] rem,
    input logic [WIDTH-1:0] quo,
    input logic [WIDTH-1:0] dvs
  );
    logic [WIDTH:0]   shifted;
    logic [WIDTH+1:0] diff;
    shifted = {rem, quo[WIDTH-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs};
    if (!diff[WIDTH+1])
      return {diff[WIDTH-1:0], quo[WIDTH-2:0], 1'b1};
    else
      return {shifted[WIDTH-1:0], quo[WIDTH-2:0], 1'b0};
  endfunction

  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic             dz_q;
  logic [SW-1:0]    nxt;

  assign nxt = restore_step(rem_q, quo_q, dvs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      dz_q  <= 1'b0;
    end else if (accept) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
      dz_q  <= (divisor == '0);
    end else if (step_en) begin
      rem_q <= nxt[SW-1:WIDTH];
      quo_q <= nxt[WIDTH-1:0];
    end
  end

  assign rem_o = rem_q;
  assign quo_o = quo_q;
  assign dz_o  = dz_q;
endmodule

// File: rtl/sdiv_final.sv
module sdiv_final #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] rem,
  input  logic [WIDTH-1:0] quo,
  input  logic             dz,
  input  logic             is_mod,
  input  logic             is_signed,
  input  logic             neg,
  input  logic             oen,
  output logic [WIDTH-1:0] res,
  output logic             ovf
);
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  function automatic logic range_bad(input logic [WIDTH-1:0] mag, input logic n);
    return n ? (mag > HALF) : (mag >= HALF);
  endfunction

  logic [WIDTH-1:0] mag;
  assign mag = is_mod ? rem : quo;

  always_comb begin
    if (dz) begin
      res = '0;
      ovf = oen;
    end else begin
      res = neg ? (~mag + 1'b1) : mag;
      ovf = oen && is_signed && range_bad(mag, neg);
    end
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             op_mod,
  input  logic             op_signed,
  input  logic             neg_res,
  input  logic             ovf_en,
  output logic [WIDTH-1:0] result,
  output logic             valid,
  output logic             overflow
);
  logic             accept, step_en, fin, busy;
  logic [WIDTH-1:0] rem_w, quo_w, res_w;
  logic             dz_w, ovf_w;
  logic             mod_q, sgn_q, neg_q, oen_q;

  sdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .step_en(step_en), .fin(fin), .busy(busy)
  );

  sdiv_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_en(step_en),
    .dividend(dividend), .divisor(divisor),
    .rem_o(rem_w), .quo_o(quo_w), .dz_o(dz_w)
  );

  sdiv_final #(.WIDTH(WIDTH)) u_final (
    .rem(rem_w), .quo(quo_w), .dz(dz_w), .is_mod(mod_q),
    .is_signed(sgn_q), .neg(neg_q), .oen(oen_q),
    .res(res_w), .ovf(ovf_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q <= 1'b0;
      sgn_q <= 1'b0;
      neg_q <= 1'b0;
      oen_q <= 1'b0;
    end else if (accept) begin
      mod_q <= op_mod;
      sgn_q <= op_signed;
      neg_q <= neg_res;
      oen_q <= ovf_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      valid    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      valid <= fin;
      if (fin) begin
        result   <= res_w;
        overflow <= ovf_w;
      end else begin
        overflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             dz,
  input logic             sgn,
  input logic             oen,
  input logic [WIDTH-1:0] result,
  input logic             valid,
  input logic             overflow
);
  logic [15:0] lat_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      seen_q <= 1'b0;
    end else if (accept) begin
      lat_q  <= '0;
      seen_q <= 1'b1;
    end else if (busy && lat_q != 16'hFFFF) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (seen_q && lat_q == 16'(WIDTH + 1)));
  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && dz) |-> (result == '0 && overflow == oen));
  p_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !dz && result == '0) |-> !overflow);
  p_ovf_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (valid && oen));
  p_unsigned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sgn && !dz) |-> !overflow);
endmodule

bind sdiv_unit sdiv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
  .dz(dz_w), .sgn(sgn_q), .oen(oen_q),
  .result(result), .valid(valid), .overflow(overflow)
);

// File: tb/tb_sdiv_unit.sv
module tb_sdiv_unit;
  localparam int BW = 16;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned MASK = (64'd1 << BW) - 1;
  localparam longint unsigned HALF = 64'd1 << (BW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] dividend = '0, divisor = '0;
  logic          op_mod = 1'b0, op_signed = 1'b0, neg_res = 1'b0, ovf_en = 1'b0;
  logic [BW-1:0] result;
  logic          valid, overflow;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  sdiv_unit #(.WIDTH(BW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .op_mod(op_mod), .op_signed(op_signed),
    .neg_res(neg_res), .ovf_en(ovf_en),
    .result(result), .valid(valid), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  function automatic longint unsigned exp_res(longint unsigned a, longint unsigned b,
                                              bit m, bit n);
    longint unsigned mag;
    if (b == 0) return 0;
    mag = m ? (a % b) : (a / b);
    return n ? ((~mag + 1) & MASK) : mag;
  endfunction

  function automatic bit exp_ovf(longint unsigned a, longint unsigned b,
                                 bit m, bit s, bit n, bit e);
    longint unsigned mag;
    if (!e) return 1'b0;
    if (b == 0) return 1'b1;
    if (!s) return 1'b0;
    mag = m ? (a % b) : (a / b);
    return n ? (mag > HALF) : (mag >= HALF);
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one operation; optionally poke a second start while busy.
  task automatic run_op(string tag, longint unsigned a, longint unsigned b,
                        bit m, bit s, bit n, bit e, bit poke);
    int k;
    @(negedge clk);
    dividend = BW'(a); divisor = BW'(b);
    op_mod = m; op_signed = s; neg_res = n; ovf_en = e;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < 200) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (poke && k == 3) begin
        // R5: stray request while busy, different operands
        dividend = ~dividend; divisor = BW'(3); op_mod = ~m; neg_res = ~n;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (valid) break;
    end
    check({tag, " R4 latency"}, k, BW + 1);
    check({tag, " result"}, result, exp_res(a, b, m, n));
    check({tag, " overflow"}, overflow, exp_ovf(a, b, m, s, n, e));
    @(posedge clk);
    @(negedge clk);
    check({tag, " R4 pulse low"}, valid, 0);
    check({tag, " R9 no ovf without valid"}, overflow, 0);
  endtask

  initial begin
    process::self().srandom(32'd12345);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 valid", valid, 0);
    check("R10 overflow", overflow, 0);
    check("R10 result", result, 0);
    rst_n = 1'b1;

    run_op("R1 quotient", 100, 7, 0, 0, 0, 1, 0);
    run_op("R2 remainder", 100, 7, 1, 0, 0, 1, 0);
    run_op("R3 negated quotient", 100, 7, 0, 1, 1, 1, 0);
    run_op("R3 negated remainder", 1000, 33, 1, 1, 1, 0, 0);
    run_op("R6 divide by zero", 1234, 0, 0, 1, 1, 1, 0);
    run_op("R6 modulus by zero", 1234, 0, 1, 0, 0, 1, 0);
    run_op("R9 zero divisor ovf disabled", 55, 0, 0, 1, 0, 0, 0);
    run_op("R7 half no negate", 16'h8000, 1, 0, 1, 0, 1, 0);
    run_op("R7 half negated", 16'h8000, 1, 0, 1, 1, 1, 0);
    run_op("R7 above half negated", 16'h8001, 1, 0, 1, 1, 1, 0);
    run_op("R7 below half", 16'h7FFF, 1, 0, 1, 0, 1, 0);
    run_op("R8 negated zero", 0, 5, 0, 1, 1, 1, 0);
    run_op("R8 negated zero remainder", 20, 5, 1, 1, 1, 1, 0);
    run_op("R11 unsigned large", 16'hFFFF, 1, 0, 0, 0, 1, 0);
    run_op("R9 signed overflow masked", 16'hFFFF, 1, 0, 1, 0, 0, 0);
    run_op("R5 start while busy", 50000, 123, 0, 0, 0, 1, 1);
    run_op("R1 max by max", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      longint unsigned a, b;
      bit m, s, n, e;
      a = longint'($urandom) & MASK;
      case ($urandom % 4)
        0: b = 0;
        1: b = 1 + ($urandom % 4);
        default: b = longint'($urandom) & MASK;
      endcase
      if ($urandom % 8 == 0) a = HALF + ($urandom % 2);
      m = 1'($urandom); s = 1'($urandom); n = 1'($urandom); e = 1'($urandom);
      run_op(m ? "R2 random" : "R1 random", a, b, m, s, n, e, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule